// File: doc/BRIEF.md
# Duplex Radio Frame Assembler

This block assembles the transmit bit stream for one end of a two-node full-duplex radio link and shifts it out serially, one bit per bit-clock enable pulse. A role input picks the master or the slave frame layout. A master frame starts with a run of ones, ends that run with a single zero start bit, then sends a three-byte sync word and the user data. A slave frame sends its own three-byte sync word followed directly by the user data. Both ends of the link must be set to the same data byte count.

Software fills a 16-byte transmit buffer through a byte-wide write port while the block is idle. The frame is laid over that buffer: the header bytes (the run of ones, the start bit and the sync word) are produced by logic, and data byte i is read from the buffer position that follows the header. A longer run of ones therefore takes buffer room away from the data. A start strobe checks the requested layout, latches the settings and begins the frame. A layout that does not fit is refused with an error pulse.

Top module: `duplex_frame_tx`

## Requirements
- R1: In master role (role_slave=0) the frame is a run of ones, then one zero start bit, then the sync bytes 0xFF, 0x00, 0x00 in that order, then the data bytes.
- R2: pb_code holds k in 0..10 and sets the run of ones to 15+8k bits. The start bit makes the header 2+k whole bytes. In master role a k above 10 is a configuration error.
- R3: In slave role (role_slave=1) the frame is the sync bytes 0x00, 0x7F, 0xFF and then the data bytes, with no run of ones and no start bit. pb_code has no effect.
- R4: Each byte goes out most significant bit first. The zero start bit is the last bit before the first sync byte.
- R5: Let H be the header length in bytes: 5+k in master role and 3 in slave role. Data byte i is taken from buffer address H+i. Buffer contents at addresses below H do not appear in the frame.
- R6: data_cnt must be between 1 and 8, and H+data_cnt must not exceed 16. Otherwise the start strobe gives a one-cycle cfg_err pulse in the following cycle and no bit and no done pulse is sent. In master role, k at 4 or above limits the data count to 11-k.
- R7: Each bit_en pulse sampled while sending produces exactly one bit. tx_valid is high for the single cycle after that clock edge. bit_en has no effect while idle.
- R8: done is a one-cycle pulse in the cycle right after the tx_valid of the last data bit.
- R9: While a frame is being sent, buffer writes and start strobes are ignored. Changes to role_slave, pb_code and data_cnt do not affect the frame in progress.
- R10: After reset, tx_valid, done and cfg_err are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| role_slave | input | 1 | 0 = master layout, 1 = slave layout |
| pb_code | input | 4 | Length code k for the run of ones (15+8k bits) |
| data_cnt | input | 4 | Number of data bytes, 1..8 |
| start | input | 1 | Start strobe, taken only while idle |
| wr_en | input | 1 | Buffer write enable, taken only while idle |
| wr_addr | input | 4 | Buffer byte address |
| wr_data | input | 8 | Buffer write data |
| bit_en | input | 1 | Bit-clock enable: one pulse per bit to send |
| tx_bit | output | 1 | Serial bit, valid when tx_valid is high |
| tx_valid | output | 1 | One-cycle strobe for each bit sent |
| done | output | 1 | One-cycle pulse after the last bit of a frame |
| cfg_err | output | 1 | One-cycle pulse when a start request is refused |

## Verification
The hardest situation to reach from the ports is a conflicting request in the middle of a frame. The stimulus must land a buffer write to a data address, a second start strobe and changed role, length and count inputs while bits are still going out. It must then show that none of them had any effect. The bench does this at a fixed bit-pulse count inside a master frame, compares the whole frame, and then sends again without reloading the buffer, so a write that slipped through would show up in the second frame. The capacity edge is also hard to cover: the runs at k=3 with 8 bytes, k=4 with 7 and 8 bytes, and k=10 with 1 and 2 bytes sit on both sides of the 16-byte limit.

// File: rtl/dfa_pkg.sv
package dfa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_FIN  = 2'd2
  } tx_state_e;

  // bytes in the sync word of either role
  localparam int SYNC_LEN = 3;
  // bytes taken by the ones run plus start bit at the shortest setting
  localparam int PB_BASE_BYTES = 2;

  // sync word byte at position pos for the chosen role
  function automatic logic [7:0] sync_byte(input logic slave, input logic [1:0] pos);
    logic [7:0] b;
    if (slave) begin
      case (pos)
        2'd0:    b = 8'h00;
        2'd1:    b = 8'h7F;
        default: b = 8'hFF;
      endcase
    end else begin
      b = (pos == 2'd0) ? 8'hFF : 8'h00;
    end
    return b;
  endfunction

endpackage

// File: rtl/dfa_cfg_check.sv
module dfa_cfg_check
  import dfa_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int MAX_DATA  = 8,
  parameter int PB_MAX    = 10,
  parameter int PB_W      = 4,
  parameter int CNT_W     = 4,
  parameter int LW        = 7
) (
  input  logic             role_slave,
  input  logic [PB_W-1:0]  pb_code,
  input  logic [CNT_W-1:0] data_cnt,
  output logic [LW-1:0]    total,
  output logic             bad
);

  logic [LW-1:0] pb_bytes;
  logic [LW-1:0] hdr_len;

  always_comb begin
    pb_bytes = LW'(pb_code) + LW'(PB_BASE_BYTES);
    hdr_len  = role_slave ? LW'(SYNC_LEN) : (pb_bytes + LW'(SYNC_LEN));
    total    = hdr_len + LW'(data_cnt);
    bad      = (data_cnt == '0)
            || (int'(data_cnt) > MAX_DATA)
            || (!role_slave && (int'(pb_code) > PB_MAX))
            || (int'(total) > BUF_BYTES);
  end

endmodule

// File: rtl/dfa_hdr_gen.sv
module dfa_hdr_gen
  import dfa_pkg::*;
#(
  parameter int PB_W = 4,
  parameter int AW   = 4,
  parameter int LW   = 7
) (
  input  logic            role_slave,
  input  logic [PB_W-1:0] pb_code,
  input  logic [AW-1:0]   idx,
  output logic            is_hdr,
  output logic            start_byte,
  output logic [7:0]      hdr_byte
);

  logic [LW-1:0] pb_bytes;
  logic [LW-1:0] pos;
  logic [LW-1:0] rel;

  always_comb begin
    pb_bytes   = role_slave ? '0 : (LW'(pb_code) + LW'(PB_BASE_BYTES));
    pos        = LW'(idx);
    rel        = pos - pb_bytes;
    is_hdr     = pos < (pb_bytes + LW'(SYNC_LEN));
    start_byte = !role_slave && (pos == (pb_bytes - LW'(1)));
    if (pos < pb_bytes) begin
      // ones run; its last byte carries the zero start bit in bit 0
      hdr_byte = start_byte ? 8'hFE : 8'hFF;
    end else begin
      hdr_byte = sync_byte(role_slave, rel[1:0]);
    end
  end

endmodule

// File: rtl/dfa_tx_buf.sv
module dfa_tx_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/duplex_frame_tx.sv
module duplex_frame_tx
  import dfa_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int MAX_DATA  = 8,
  parameter int PB_MAX    = 10,
  parameter int PB_W      = 4,
  parameter int CNT_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          role_slave,
  input  logic [PB_W-1:0]               pb_code,
  input  logic [CNT_W-1:0]              data_cnt,
  input  logic                          start,
  input  logic                          wr_en,
  input  logic [$clog2(BUF_BYTES)-1:0]  wr_addr,
  input  logic [7:0]                    wr_data,
  input  logic                          bit_en,
  output logic                          tx_bit,
  output logic                          tx_valid,
  output logic                          done,
  output logic                          cfg_err
);

  localparam int AW = $clog2(BUF_BYTES);
  localparam int LW = AW + 3;

  tx_state_e       st_q, st_d;
  logic            role_q, role_d;
  logic [PB_W-1:0] pb_q, pb_d;
  logic [AW-1:0]   byte_q, byte_d;
  logic [AW-1:0]   last_q, last_d;
  logic [2:0]      bit_q, bit_d;
  logic            tx_bit_q, tx_bit_d;
  logic            tx_valid_q, tx_valid_d;
  logic            done_q, done_d;
  logic            err_q, err_d;

  logic [LW-1:0]   cfg_total;
  logic            cfg_bad;
  logic            is_hdr;
  logic            start_byte;
  logic [7:0]      hdr_byte;
  logic [7:0]      buf_byte;
  logic [7:0]      cur_byte;
  logic            buf_we;

  dfa_cfg_check #(
    .BUF_BYTES (BUF_BYTES),
    .MAX_DATA  (MAX_DATA),
    .PB_MAX    (PB_MAX),
    .PB_W      (PB_W),
    .CNT_W     (CNT_W),
    .LW        (LW)
  ) u_cfg (
    .role_slave (role_slave),
    .pb_code    (pb_code),
    .data_cnt   (data_cnt),
    .total      (cfg_total),
    .bad        (cfg_bad)
  );

  dfa_hdr_gen #(
    .PB_W (PB_W),
    .AW   (AW),
    .LW   (LW)
  ) u_hdr (
    .role_slave (role_q),
    .pb_code    (pb_q),
    .idx        (byte_q),
    .is_hdr     (is_hdr),
    .start_byte (start_byte),
    .hdr_byte   (hdr_byte)
  );

  // the buffer is written only while idle
  assign buf_we = wr_en && (st_q == ST_IDLE);

  dfa_tx_buf #(
    .DEPTH (BUF_BYTES),
    .AW    (AW)
  ) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (byte_q),
    .rdata (buf_byte)
  );

  assign cur_byte = is_hdr ? hdr_byte : buf_byte;

  // next-state logic
  always_comb begin
    st_d       = st_q;
    role_d     = role_q;
    pb_d       = pb_q;
    byte_d     = byte_q;
    last_d     = last_q;
    bit_d      = bit_q;
    tx_bit_d   = tx_bit_q;
    tx_valid_d = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (cfg_bad) begin
            err_d = 1'b1;
          end else begin
            role_d = role_slave;
            pb_d   = pb_code;
            byte_d = '0;
            bit_d  = 3'd7;
            last_d = AW'(cfg_total - LW'(1));
            st_d   = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        if (bit_en) begin
          tx_valid_d = 1'b1;
          tx_bit_d   = cur_byte[bit_q];
          if (bit_q == 3'd0) begin
            bit_d = 3'd7;
            if (byte_q == last_q) begin
              st_d = ST_FIN;
            end else begin
              byte_d = byte_q + AW'(1);
            end
          end else begin
            bit_d = bit_q - 3'd1;
          end
        end
      end
      ST_FIN: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      role_q     <= 1'b0;
      pb_q       <= '0;
      byte_q     <= '0;
      last_q     <= '0;
      bit_q      <= 3'd7;
      tx_bit_q   <= 1'b0;
      tx_valid_q <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      role_q     <= role_d;
      pb_q       <= pb_d;
      byte_q     <= byte_d;
      last_q     <= last_d;
      bit_q      <= bit_d;
      tx_bit_q   <= tx_bit_d;
      tx_valid_q <= tx_valid_d;
      done_q     <= done_d;
      err_q      <= err_d;
    end
  end

  assign tx_bit   = tx_bit_q;
  assign tx_valid = tx_valid_q;
  assign done     = done_q;
  assign cfg_err  = err_q;

  // R7: a bit strobe only follows a bit-clock enable
  a_r7_valid_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_q |-> $past(bit_en));

  // R8: done comes right after the last bit strobe
  a_r8_done_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(tx_valid_q));

  // R8: done lasts one cycle
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: a refused request leaves the block silent and idle
  a_r6_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st_q == ST_IDLE && !tx_valid_q && !done_q));

  // R6: an accepted request starts sending
  a_r6_accept_sends: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && !cfg_bad) |=> (st_q == ST_SEND));

  // R4: the bit sent from bit 0 of the last ones-run byte is the zero start bit
  a_r4_start_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SEND && bit_en && start_byte && bit_q == 3'd0) |=> !tx_bit_q);

endmodule

// File: tb/duplex_frame_tx_bench.sv
module duplex_frame_tx_bench;

  logic       clk;
  logic       rst_n;
  logic       role_slave;
  logic [3:0] pb_code;
  logic [3:0] data_cnt;
  logic       start;
  logic       wr_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic       bit_en;
  logic       tx_bit;
  logic       tx_valid;
  logic       done;
  logic       cfg_err;

  int n_chk;
  int n_bad;
  int cyc_all;

  bit exp_bits [256];
  int exp_n;
  bit got_bits [256];
  int got_n;

  duplex_frame_tx u_duplex_frame_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .role_slave (role_slave),
    .pb_code    (pb_code),
    .data_cnt   (data_cnt),
    .start      (start),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .bit_en     (bit_en),
    .tx_bit     (tx_bit),
    .tx_valid   (tx_valid),
    .done       (done),
    .cfg_err    (cfg_err)
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc_all);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input int seed, input int i);
    return 8'(seed * 11 + i * 37 + 5);
  endfunction

  function automatic int hdr_bytes(input bit slave, input int k);
    return slave ? 3 : 5 + k;
  endfunction

  task automatic push_byte(input logic [7:0] b);
    for (int j = 7; j >= 0; j--) begin
      exp_bits[exp_n] = b[j];
      exp_n++;
    end
  endtask

  // expected frame from the requirements (R1, R2, R3, R4, R5)
  task automatic build_exp(input bit slave, input int k, input int cnt, input int seed);
    exp_n = 0;
    if (slave) begin
      push_byte(8'h00); push_byte(8'h7F); push_byte(8'hFF);
    end else begin
      for (int j = 0; j < k + 1; j++) push_byte(8'hFF);
      push_byte(8'hFE);
      push_byte(8'hFF); push_byte(8'h00); push_byte(8'h00);
    end
    for (int i = 0; i < cnt; i++) push_byte(dbyte(seed, i));
  endtask

  task automatic write_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 4'(a);
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic load_data(input bit slave, input int k, input int cnt, input int seed);
    int h;
    h = hdr_bytes(slave, k);
    // header positions hold junk that must never reach the line (R5)
    write_byte(0, 8'h00);
    write_byte(h - 1, 8'h5A);
    for (int i = 0; i < cnt; i++) write_byte(h + i, dbyte(seed, i));
  endtask

  task automatic run_frame(input bit slave, input int k, input int cnt, input int seed,
                           input bit do_load, input bit disturb, input string req);
    int last_v;
    int done_cyc;
    int mism;
    int first_bad;
    int h;
    h = hdr_bytes(slave, k);
    if (do_load) load_data(slave, k, cnt, seed);
    build_exp(slave, k, cnt, seed);
    @(negedge clk);
    role_slave = slave;
    pb_code    = 4'(k);
    data_cnt   = 4'(cnt);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err == 1'b0, req, "cfg_err on valid request", int'(cfg_err), 0);
    got_n = 0; last_v = -10; done_cyc = -1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (tx_valid) begin
        if (got_n < 256) got_bits[got_n] = tx_bit;
        got_n++;
        last_v = c;
      end
      if (done) begin
        done_cyc = c;
        break;
      end
      bit_en = (c % 2 == 0);
      if (disturb && c == 20) begin
        wr_en      = 1'b1;
        wr_addr    = 4'(h);
        wr_data    = ~dbyte(seed, 0);
        start      = 1'b1;
        role_slave = ~slave;
        pb_code    = 4'(k + 1);
        data_cnt   = 4'd1;
      end else if (disturb && c == 21) begin
        wr_en = 1'b0;
        start = 1'b0;
      end
    end
    bit_en = 1'b0; wr_en = 1'b0; start = 1'b0;
    check(got_n == exp_n, req, "bit count", got_n, exp_n);
    mism = 0; first_bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      if (got_bits[i] != exp_bits[i]) begin
        if (first_bad < 0) first_bad = i;
        mism++;
      end
    end
    check(mism == 0, req, "mismatched bits (first index in next line if any)", mism, 0);
    if (first_bad >= 0)
      $display("  first differing bit index %0d got %0d", first_bad, got_bits[first_bad]);
    check(done_cyc == last_v + 1, "R8", "done cycle vs last bit", done_cyc, last_v + 1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done width", int'(done), 0);
  endtask

  task automatic run_err(input bit slave, input int k, input int cnt, input string req);
    int seen;
    @(negedge clk);
    role_slave = slave;
    pb_code    = 4'(k);
    data_cnt   = 4'(cnt);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfg_err == 1'b1, req, "cfg_err on refused request", int'(cfg_err), 1);
    seen = 0;
    for (int c = 0; c < 40; c++) begin
      bit_en = (c % 2 == 0);
      @(negedge clk);
      if (tx_valid || done || cfg_err) seen++;
    end
    bit_en = 1'b0;
    check(seen == 0, req, "activity after refused request", seen, 0);
  endtask

  task automatic test_reset;
    int seen;
    check(tx_valid == 1'b0, "R10", "tx_valid after reset", int'(tx_valid), 0);
    check(done == 1'b0, "R10", "done after reset", int'(done), 0);
    check(cfg_err == 1'b0, "R10", "cfg_err after reset", int'(cfg_err), 0);
    seen = 0;
    for (int c = 0; c < 12; c++) begin
      bit_en = (c % 2 == 0);
      @(negedge clk);
      if (tx_valid) seen++;
    end
    bit_en = 1'b0;
    check(seen == 0, "R7", "bit strobes while idle", seen, 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; cyc_all = 0;
    rst_n = 1'b0; role_slave = 1'b0; pb_code = '0; data_cnt = '0;
    start = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; bit_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    test_reset();
    run_frame(1'b0, 0, 8, 1, 1'b1, 1'b0, "R1");   // shortest ones run, full data, R4 R5
    run_frame(1'b0, 3, 8, 2, 1'b1, 1'b0, "R6");   // 39-bit run, still 8 bytes
    run_frame(1'b0, 4, 7, 3, 1'b1, 1'b0, "R6");   // 47-bit run, 7 bytes fill 16
    run_frame(1'b0, 10, 1, 4, 1'b1, 1'b0, "R2");  // 95-bit run, one byte
    pb_code = 4'd7;
    run_frame(1'b1, 7, 8, 5, 1'b1, 1'b0, "R3");   // slave, pb_code ignored
    run_frame(1'b1, 0, 1, 6, 1'b1, 1'b0, "R3");
    run_err(1'b0, 4, 8, "R6");
    run_err(1'b0, 10, 2, "R6");
    run_err(1'b0, 11, 1, "R2");
    run_err(1'b0, 0, 0, "R6");
    run_err(1'b1, 0, 9, "R6");
    run_frame(1'b0, 1, 4, 7, 1'b1, 1'b1, "R9");   // disturbed mid-frame
    run_frame(1'b0, 1, 4, 7, 1'b0, 1'b0, "R9");   // buffer unchanged by busy write
    run_frame(1'b0, 2, 6, 8, 1'b1, 1'b0, "R5");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule